// File: doc/BRIEF.md
# Passive serial configuration sequencer

This block is the master side of a passive serial load into a target FPGA. A start command sets off a timed handshake. The block holds a configuration request line asserted for a minimum pulse and confirms that the target reports reset. It then releases the request and polls the target's status line at a fixed interval, up to a limit. Once status clears, it waits a settle time and only then accepts bitstream bytes from a valid/ready byte stream, serialising each one onto a data and clock pair. After the byte marked last, it checks the status and configuration-done lines. If both are clean, it clocks out one extra all-zero byte so the target can initialise.

A static profile input picks one of two timing sets: a short one and a long one. All delays are counted in system clocks derived from a clock-frequency parameter. Both inputs from the target pass through synchronisers. The result is a busy flag, a one-cycle done pulse and a 3-bit error code. The error code stays valid until the next start.

Top module: `pscfg_sequencer`

## Requirements
- R1: Out of reset, and whenever no byte is being shifted, the serial clock and data outputs are low. After reset, busy, done, request and ready are low and the error code is 0.
- R2: A start with the partial flag set leaves every target pin untouched and does not go busy. It sets the error code to 5.
- R3: On a normal start the request output rises and stays high for at least RST_US microseconds. If the synchronised status input is not active at the end of that pulse, the request is released and the load ends with error code 1.
- R4: After the request falls, status is sampled once every POLL_US microseconds, for at most ceil(max/POLL_US) samples. Here max is WAITMAX_A_US (profile input 0) or WAITMAX_B_US (profile input 1). If status is still active at the last sample, the load ends with error code 2.
- R5: Once a poll finds status inactive, ready stays low for SETTLE_A_US (profile 0) or SETTLE_B_US (profile 1) microseconds before it first rises. Ready is never high while the request is asserted.
- R6: Each accepted byte produces 8 rising clock edges, with data stable across each rising edge. With the bit-order input at 0, bit 0 of the byte goes out first and bit 7 last. With it at 1, the byte is treated as already reversed: bit 7 goes out first.
- R7: After the last byte has been shifted, an active status input ends the load with error code 3 and no further clock edges.
- R8: After the last byte, if the done check input is 1 and the configuration-done input is low, the load ends with error code 4. With the done check input at 0, a low configuration-done input has no effect.
- R9: A clean finish sends 8 further rising clock edges with data low, then raises done for exactly one cycle with error code 0.
- R10: The error code is 0 while busy. It changes only in the cycle a load ends or a start is taken, and is held otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken while not busy |
| partial_i | input | 1 | Start asks for partial reconfiguration (rejected) |
| lsb_first_i | input | 1 | 1: bytes already bit-reversed, send bit 7 first |
| cdone_chk_i | input | 1 | 1: check configuration-done at the end |
| profile_i | input | 1 | Timing profile select, 0 = short, 1 = long |
| s_data | input | 8 | Bitstream byte |
| s_valid | input | 1 | Byte valid |
| s_last | input | 1 | Byte is the final one of the stream |
| s_ready | output | 1 | Block accepts a byte this cycle |
| tgt_req_o | output | 1 | Configuration request to target, active high |
| tgt_stat_i | input | 1 | Target status, 1 = in reset or error |
| tgt_cdone_i | input | 1 | Target configuration done, 1 = done |
| ps_data_o | output | 1 | Serial data to target |
| ps_clk_o | output | 1 | Serial clock to target, idle low |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 3 | Error code: 0 none, 1 no reset, 2 timeout, 3 status at end, 4 done low, 5 unsupported |

## Verification
The hardest behaviour to reach from the ports is the poll limit under each profile. It only shows when the target keeps status active past every poll, and the difference between profiles lies in how many poll intervals pass before the timeout. The bench models the target's status line with a programmable release delay after the request falls. It sets that delay beyond the longest window and measures the cycles from the request's falling edge to the end of busy, so a wrong poll count or interval changes the measured value. The same model releases status between polls to measure the settle gap before ready. A separate forcing input holds status active after the last byte.

// File: rtl/pscfg_pkg.sv
package pscfg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RSTP,
      ST_POLL,
      ST_SETTLE,
      ST_STREAM,
      ST_ENDCHK,
      ST_TRAIL
   } pscfg_state_e;

   typedef enum logic [2:0] {
      ERR_NONE   = 3'd0,
      ERR_NORST  = 3'd1,
      ERR_TMO    = 3'd2,
      ERR_STAT   = 3'd3,
      ERR_CDONE  = 3'd4,
      ERR_UNSUP  = 3'd5
   } pscfg_err_e;

   function automatic logic [7:0] bitrev8(input logic [7:0] b);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = b[7-i];
      return r;
   endfunction

   function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
      return (a + b - 1) / b;
   endfunction

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pscfg_sync.sv
module pscfg_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pscfg_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("pscfg_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/pscfg_timer.sv
module pscfg_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         expired
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (load)          cnt <= val - W'(1);
      else if (cnt != '0)     cnt <= cnt - W'(1);
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/pscfg_shifter.sv
module pscfg_shifter #(
   parameter int HALF_CYC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] word,
   output logic       busy,
   output logic       fin,
   output logic       sdo,
   output logic       sck
);

   localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

   generate
      if (HALF_CYC < 1) begin : g_bad_half
         $error("pscfg_shifter: HALF_CYC must be at least 1");
      end
   endgenerate

   logic       act;
   logic [7:0] sh;
   logic [2:0] bc;
   logic       tick;
   logic       take;

   assign take = load && !act;

   generate
      if (HALF_CYC == 1) begin : g_nodiv
         assign tick = act;
      end else begin : g_div
         logic [HW-1:0] hc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      hc <= '0;
            else if (take)   hc <= HW'(HALF_CYC - 1);
            else if (act)    hc <= (hc == '0) ? HW'(HALF_CYC - 1) : hc - HW'(1);
         end
         assign tick = act && (hc == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act <= 1'b0;
         sh  <= '0;
         bc  <= '0;
         sck <= 1'b0;
         fin <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (take) begin
            act <= 1'b1;
            sh  <= word;
            bc  <= '0;
            sck <= 1'b0;
         end else if (tick) begin
            if (!sck) begin
               sck <= 1'b1;
            end else begin
               sck <= 1'b0;
               if (bc == 3'd7) begin
                  act <= 1'b0;
                  fin <= 1'b1;
               end else begin
                  bc <= bc + 3'd1;
                  sh <= {sh[6:0], 1'b0};
               end
            end
         end
      end
   end

   assign busy = act;
   assign sdo  = act & sh[7];

endmodule

// File: rtl/pscfg_sequencer.sv
module pscfg_sequencer
   import pscfg_pkg::*;
#(
   parameter int CLK_HZ       = 50_000_000,
   parameter int RST_US       = 2,
   parameter int POLL_US      = 268,
   parameter int WAITMAX_A_US = 1506,
   parameter int WAITMAX_B_US = 3000,
   parameter int SETTLE_A_US  = 2,
   parameter int SETTLE_B_US  = 10,
   parameter int HALF_CYC     = 2,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       partial_i,
   input  logic       lsb_first_i,
   input  logic       cdone_chk_i,
   input  logic       profile_i,
   input  logic [7:0] s_data,
   input  logic       s_valid,
   input  logic       s_last,
   output logic       s_ready,
   output logic       tgt_req_o,
   input  logic       tgt_stat_i,
   input  logic       tgt_cdone_i,
   output logic       ps_data_o,
   output logic       ps_clk_o,
   output logic       busy_o,
   output logic       done_o,
   output logic [2:0] err_o
);

   localparam int CYC_US       = CLK_HZ / 1_000_000;
   localparam int RST_CYC      = RST_US * CYC_US;
   localparam int POLL_CYC     = POLL_US * CYC_US;
   localparam int SETTLE_A_CYC = SETTLE_A_US * CYC_US;
   localparam int SETTLE_B_CYC = SETTLE_B_US * CYC_US;
   localparam int NPOLL_A      = ceil_div(WAITMAX_A_US, POLL_US);
   localparam int NPOLL_B      = ceil_div(WAITMAX_B_US, POLL_US);
   localparam int MAX_CYC      = max3(RST_CYC, POLL_CYC,
                                      (SETTLE_A_CYC > SETTLE_B_CYC) ? SETTLE_A_CYC : SETTLE_B_CYC);
   localparam int TMR_W        = $clog2(MAX_CYC + 1);
   localparam int NPOLL_MAX    = (NPOLL_A > NPOLL_B) ? NPOLL_A : NPOLL_B;
   localparam int PCNT_W       = $clog2(NPOLL_MAX + 1);

   generate
      if (CLK_HZ < 1_000_000 || (CLK_HZ % 1_000_000) != 0) begin : g_bad_clk
         $error("pscfg_sequencer: CLK_HZ must be a whole number of MHz");
      end
      if (RST_US < 1 || POLL_US < 1 || SETTLE_A_US < 1 || SETTLE_B_US < 1) begin : g_bad_time
         $error("pscfg_sequencer: every delay must be at least 1 us");
      end
      if (WAITMAX_A_US < POLL_US || WAITMAX_B_US < POLL_US) begin : g_bad_wait
         $error("pscfg_sequencer: wait limits must cover at least one poll");
      end
   endgenerate

   // target inputs through synchronisers
   logic [1:0] tgt_raw, tgt_sync;
   logic       stat_s, cd_s;

   assign tgt_raw = {tgt_cdone_i, tgt_stat_i};

   pscfg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (tgt_raw),
      .q     (tgt_sync)
   );

   assign stat_s = tgt_sync[0];
   assign cd_s   = tgt_sync[1];

   // delay timer
   logic             tmr_load;
   logic [TMR_W-1:0] tmr_val;
   logic             tmr_exp;

   pscfg_timer #(.W(TMR_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .val     (tmr_val),
      .expired (tmr_exp)
   );

   // serial shifter
   logic       sh_load, sh_busy, sh_fin;
   logic [7:0] sh_word;

   pscfg_shifter #(.HALF_CYC(HALF_CYC)) u_shf (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (sh_load),
      .word  (sh_word),
      .busy  (sh_busy),
      .fin   (sh_fin),
      .sdo   (ps_data_o),
      .sck   (ps_clk_o)
   );

   // control state
   pscfg_state_e      st;
   pscfg_err_e        err_q;
   logic              req_q, done_q, prof_q, lsbf_q, cdchk_q, last_q;
   logic [PCNT_W-1:0] pcnt;
   logic [PCNT_W-1:0] pcnt_last;
   logic              hs;
   logic              go_full, go_part;
   logic              end_ok;

   assign go_full   = (st == ST_IDLE) && start_i && !partial_i;
   assign go_part   = (st == ST_IDLE) && start_i &&  partial_i;
   assign pcnt_last = prof_q ? PCNT_W'(NPOLL_B - 1) : PCNT_W'(NPOLL_A - 1);
   assign s_ready   = (st == ST_STREAM) && !sh_busy && !last_q;
   assign hs        = s_ready && s_valid;
   assign end_ok    = !stat_s && !(cdchk_q && !cd_s);

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      sh_load  = 1'b0;
      sh_word  = '0;
      unique case (st)
         ST_IDLE: begin
            if (go_full) begin
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(RST_CYC);
            end
         end
         ST_RSTP: begin
            if (tmr_exp && stat_s) begin
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(POLL_CYC);
            end
         end
         ST_POLL: begin
            if (tmr_exp) begin
               if (!stat_s) begin
                  tmr_load = 1'b1;
                  tmr_val  = prof_q ? TMR_W'(SETTLE_B_CYC) : TMR_W'(SETTLE_A_CYC);
               end else if (pcnt != pcnt_last) begin
                  tmr_load = 1'b1;
                  tmr_val  = TMR_W'(POLL_CYC);
               end
            end
         end
         ST_STREAM: begin
            if (hs) begin
               sh_load = 1'b1;
               sh_word = lsbf_q ? s_data : bitrev8(s_data);
            end
         end
         ST_ENDCHK: begin
            if (end_ok) begin
               sh_load = 1'b1;
               sh_word = 8'h00;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         err_q   <= ERR_NONE;
         req_q   <= 1'b0;
         done_q  <= 1'b0;
         prof_q  <= 1'b0;
         lsbf_q  <= 1'b0;
         cdchk_q <= 1'b0;
         last_q  <= 1'b0;
         pcnt    <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (go_part) begin
                  err_q <= ERR_UNSUP;
               end else if (go_full) begin
                  err_q   <= ERR_NONE;
                  req_q   <= 1'b1;
                  prof_q  <= profile_i;
                  lsbf_q  <= lsb_first_i;
                  cdchk_q <= cdone_chk_i;
                  last_q  <= 1'b0;
                  pcnt    <= '0;
                  st      <= ST_RSTP;
               end
            end
            ST_RSTP: begin
               if (tmr_exp) begin
                  req_q <= 1'b0;
                  if (stat_s) begin
                     st <= ST_POLL;
                  end else begin
                     err_q <= ERR_NORST;
                     st    <= ST_IDLE;
                  end
               end
            end
            ST_POLL: begin
               if (tmr_exp) begin
                  if (!stat_s) begin
                     st <= ST_SETTLE;
                  end else if (pcnt == pcnt_last) begin
                     err_q <= ERR_TMO;
                     st    <= ST_IDLE;
                  end else begin
                     pcnt <= pcnt + PCNT_W'(1);
                  end
               end
            end
            ST_SETTLE: begin
               if (tmr_exp) st <= ST_STREAM;
            end
            ST_STREAM: begin
               if (hs && s_last) last_q <= 1'b1;
               if (sh_fin && last_q) st <= ST_ENDCHK;
            end
            ST_ENDCHK: begin
               if (stat_s) begin
                  err_q <= ERR_STAT;
                  st    <= ST_IDLE;
               end else if (cdchk_q && !cd_s) begin
                  err_q <= ERR_CDONE;
                  st    <= ST_IDLE;
               end else begin
                  st <= ST_TRAIL;
               end
            end
            ST_TRAIL: begin
               if (sh_fin) begin
                  done_q <= 1'b1;
                  st     <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign tgt_req_o = req_q;
   assign busy_o    = (st != ST_IDLE);
   assign done_o    = done_q;
   assign err_o     = err_q;

endmodule

// File: rtl/pscfg_checker.sv
module pscfg_checker #(
   parameter int CLK_HZ = 50_000_000,
   parameter int RST_US = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       partial_i,
   input logic       s_ready,
   input logic       tgt_req_o,
   input logic       ps_clk_o,
   input logic       ps_data_o,
   input logic       busy_o,
   input logic       done_o,
   input logic [2:0] err_o
);

   localparam int MIN_PULSE = (CLK_HZ / 1_000_000) * RST_US;

   logic [15:0] req_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          req_run <= '0;
      else if (tgt_req_o)  req_run <= req_run + 16'd1;
      else                 req_run <= '0;
   end

   AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!ps_clk_o && !ps_data_o));                                        // R1

   AST_PARTIAL_NO_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && partial_i && !busy_o) |=> (!tgt_req_o && !busy_o && err_o == 3'd5)); // R2

   AST_RST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tgt_req_o) |-> (req_run >= 16'(MIN_PULSE)));                             // R3

   AST_READY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> (busy_o && !tgt_req_o));                                           // R5

   AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (err_o == 3'd0 && !busy_o));                                        // R9

   AST_BUSY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (err_o == 3'd0));                                                   // R10

   AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(err_o));                                     // R10

   AST_ERR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o <= 3'd5);                                                                // R10

endmodule

bind pscfg_sequencer pscfg_checker #(.CLK_HZ(CLK_HZ), .RST_US(RST_US)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .partial_i (partial_i),
   .s_ready   (s_ready),
   .tgt_req_o (tgt_req_o),
   .ps_clk_o  (ps_clk_o),
   .ps_data_o (ps_data_o),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .err_o     (err_o)
);

// File: tb/tb_pscfg_sequencer.sv
`timescale 1ns/1ps
module tb_pscfg_sequencer;

   // 2 clocks per microsecond in the timing parameters keeps waits short
   localparam int CLK_HZ   = 2_000_000;
   localparam int CYC_US   = 2;
   localparam int RST_CYC  = 2 * CYC_US;
   localparam int POLL_CYC = 268 * CYC_US;
   localparam int SET_A    = 2 * CYC_US;
   localparam int SET_B    = 10 * CYC_US;
   localparam int NP_A     = 6;
   localparam int NP_B     = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 0, partial_i = 0, lsb_first_i = 0, cdone_chk_i = 0, profile_i = 0;
   logic [7:0] s_data = 0;
   logic       s_valid = 0, s_last = 0;
   logic       s_ready, tgt_req_o, tgt_stat_i, ps_data_o, ps_clk_o, busy_o, done_o;
   logic       tgt_cdone_i = 0;
   logic [2:0] err_o;

   always #10 clk = ~clk;

   pscfg_sequencer #(.CLK_HZ(CLK_HZ), .HALF_CYC(2)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .partial_i(partial_i),
      .lsb_first_i(lsb_first_i), .cdone_chk_i(cdone_chk_i), .profile_i(profile_i),
      .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
      .tgt_req_o(tgt_req_o), .tgt_stat_i(tgt_stat_i), .tgt_cdone_i(tgt_cdone_i),
      .ps_data_o(ps_data_o), .ps_clk_o(ps_clk_o), .busy_o(busy_o), .done_o(done_o),
      .err_o(err_o)
   );

   // target model: status follows the request, released a set time after it falls
   logic mdl_stat = 0, respond = 1, force_err = 0;
   int   rel_delay = 700, rel_cnt = 0;
   always @(posedge clk) begin
      if (tgt_req_o) begin
         mdl_stat <= respond;
         rel_cnt  <= rel_delay;
      end else if (rel_cnt != 0) rel_cnt <= rel_cnt - 1;
      else mdl_stat <= 1'b0;
   end
   assign tgt_stat_i = mdl_stat | force_err;

   // serial capture and activity monitors
   logic bits [0:255];
   int   nbits = 0, done_cyc = 0, req_seen = 0;
   always @(posedge ps_clk_o) begin
      if (nbits < 256) bits[nbits] = ps_data_o;
      nbits = nbits + 1;
   end
   always @(negedge clk) begin
      if (done_o) done_cyc = done_cyc + 1;
      if (tgt_req_o) req_seen = 1;
   end

   int n_chk = 0, n_bad = 0;
   logic [7:0] tx [0:15];
   int ntx = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clear_mon();
      nbits = 0; done_cyc = 0; req_seen = 0;
   endtask

   task automatic kick(input bit part, input bit lsbf, input bit prof, input bit cdchk);
      @(negedge clk);
      partial_i = part; lsb_first_i = lsbf; profile_i = prof; cdone_chk_i = cdchk;
      start_i = 1;
      @(negedge clk);
      start_i = 0; partial_i = 0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 20000 && busy_o; i++) @(negedge clk);
   endtask

   // counts request-high cycles, then cycles from its fall until ready or idle
   task automatic measure(output int hi, output int gap);
      hi = 0; gap = 0;
      while (!tgt_req_o && busy_o) @(negedge clk);
      while (tgt_req_o) begin hi++; @(negedge clk); end
      while (!s_ready && busy_o && gap < 20000) begin gap++; @(negedge clk); end
   endtask

   task automatic send_all(input bit stat_at_end);
      for (int k = 0; k < ntx; k++) begin
         s_data = tx[k]; s_last = (k == ntx - 1); s_valid = 1;
         if (k == ntx - 1 && stat_at_end) force_err = 1;
         while (!s_ready) @(negedge clk);
         @(negedge clk);
      end
      s_valid = 0; s_last = 0;
   endtask

   task automatic check_bits(input bit lsbf, input int nb, input string tag);
      int bad = 0;
      for (int k = 0; k < ntx; k++)
         for (int b = 0; b < 8; b++)
            if (bits[k*8+b] !== (lsbf ? tx[k][7-b] : tx[k][b])) bad++;
      for (int b = 0; b < nb; b++)
         if (bits[ntx*8+b] !== 1'b0) bad++;
      chk(bad == 0, tag, bad, 0);
   endtask

   task automatic t_reset();
      chk(!busy_o && !done_o && !tgt_req_o && !s_ready, "R1 idle outputs after reset",
          {busy_o, done_o, tgt_req_o, s_ready}, 0);
      chk(!ps_clk_o && !ps_data_o, "R1 serial lines low after reset", {ps_clk_o, ps_data_o}, 0);
      chk(err_o == 0, "R1 error code after reset", err_o, 0);
   endtask

   task automatic t_partial();
      clear_mon();
      kick(1, 0, 0, 0);
      repeat (5) @(negedge clk);
      chk(err_o == 5, "R2 partial start error code", err_o, 5);
      chk(req_seen == 0 && !busy_o, "R2 no request, not busy", req_seen, 0);
   endtask

   task automatic t_noreset();
      int hi, gap;
      clear_mon(); respond = 0;
      kick(0, 0, 0, 0);
      measure(hi, gap);
      wait_idle();
      chk(hi >= RST_CYC, "R3 request pulse length", hi, RST_CYC);
      chk(err_o == 1, "R3 no reset seen error", err_o, 1);
      repeat (20) @(negedge clk);
      chk(err_o == 1, "R10 error held while idle", err_o, 1);
      respond = 1;
   endtask

   task automatic t_timeout(input bit prof);
      int hi, gap, exp;
      clear_mon(); rel_delay = 100000;
      kick(0, 0, prof, 0);
      @(negedge clk);
      chk(err_o == 0, "R10 error cleared by start", err_o, 0);
      measure(hi, gap);
      exp = (prof ? NP_B : NP_A) * POLL_CYC;
      chk(gap >= exp - 1 && gap <= exp + 2,
          prof ? "R4 timeout window profile B" : "R4 timeout window profile A", gap, exp);
      chk(err_o == 2, "R4 status timeout error", err_o, 2);
      rel_delay = 700;
      repeat (710) @(negedge clk);
   endtask

   task automatic t_load(input bit prof, input bit lsbf, input bit cdchk, input bit cdval,
                         input bit stat_end, input int exp_err, input string tag);
      int hi, gap, exp;
      clear_mon(); tgt_cdone_i = cdval; rel_delay = 700;
      kick(0, lsbf, prof, cdchk);
      measure(hi, gap);
      chk(hi >= RST_CYC && hi <= RST_CYC + 2, "R3 request pulse in load", hi, RST_CYC);
      exp = 2 * POLL_CYC + (prof ? SET_B : SET_A);
      chk(gap >= exp - 1 && gap <= exp + 2, "R5 settle before ready", gap, exp);
      send_all(stat_end);
      wait_idle();
      force_err = 0;
      @(negedge clk);
      chk(err_o == exp_err, tag, err_o, exp_err);
      chk(!ps_clk_o && !ps_data_o, "R1 serial lines low after load", {ps_clk_o, ps_data_o}, 0);
      if (exp_err == 0) begin
         chk(nbits == ntx * 8 + 8, "R9 trailing clock count", nbits, ntx * 8 + 8);
         chk(done_cyc == 1, "R9 done pulse width", done_cyc, 1);
         check_bits(lsbf, 8, lsbf ? "R6 bit order pre-reversed" : "R6 bit order default");
      end else begin
         chk(nbits == ntx * 8, "R7 no trailing clocks on error", nbits, ntx * 8);
         chk(done_cyc == 0, "R8 no done pulse on error", done_cyc, 0);
         check_bits(lsbf, 0, "R6 data bits before error");
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_partial();
      t_noreset();
      t_timeout(0);
      t_timeout(1);
      tx[0] = 8'h01; tx[1] = 8'hA5; tx[2] = 8'h3C; ntx = 3;
      t_load(0, 0, 1, 1, 0, 0, "R9 clean finish profile A");
      tx[0] = 8'h80; tx[1] = 8'h5A; ntx = 2;
      t_load(1, 1, 1, 1, 0, 0, "R9 clean finish profile B");
      tx[0] = 8'hC3; tx[1] = 8'h0F; ntx = 2;
      t_load(0, 0, 0, 0, 1, 3, "R7 status active at end");
      t_load(0, 0, 1, 0, 0, 4, "R8 done inactive error");
      t_load(0, 1, 0, 0, 0, 0, "R8 done input ignored when check off");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule